// File: doc/BRIEF.md
# Four-Mode Bidirectional Shift Register

This block is a four-bit storage register whose operation is picked at every rising clock edge by a two-bit mode input. The register can keep its contents, shift toward bit 0, shift toward bit 3, or take a full parallel word. Each shift direction has its own serial input bit. The bit entering at bit 3 during a shift toward bit 0 comes from one input. The bit entering at bit 0 during a shift toward bit 3 comes from the other. All four register bits drive the output directly.

Inside the block, a small control module turns the reset and the mode code into a set of one-hot strobes. A datapath module applies those strobes to every bit, using a generated per-bit selector. The output comes straight from flip-flops, so nothing on the mode or data inputs can reach it between clock edges. A synchronous reset clears the register and overrides every mode.

Top module: `bidirShiftReg`

## Requirements
- R1: When `rst` is 1 at a rising edge, `regOut` becomes 0000 after that edge, whatever the mode, serial and load inputs are.
- R2: Mode code 2'b00 (keep) leaves `regOut` unchanged across the edge.
- R3: Mode code 2'b01 (shift toward bit 0) gives `regOut` = {serInHigh, old regOut[3:1]}. Bit 3 takes `serInHigh`.
- R4: Mode code 2'b10 (shift toward bit 3) gives `regOut` = {old regOut[2:0], serInLow}. Bit 0 takes `serInLow`.
- R5: Mode code 2'b11 (load) gives `regOut` = `loadWord`.
- R6: `regOut` changes only at a rising clock edge. Changing `mode` or `loadWord` between edges leaves `regOut` as it was until the next edge.
- R7: A serial input that does not feed the current operation has no effect. `serInLow` is ignored in mode 01. `serInHigh` is ignored in mode 10. Both are ignored in modes 00 and 11. `loadWord` is ignored in every mode except 11.
- R8: Starting from 1010, two shifts toward bit 0 with `serInHigh`=1 give 1101 and then 1110. A following shift toward bit 3 with `serInLow`=0 gives 1100. Loading 0110 and then shifting toward bit 3 with `serInLow`=0 gives 1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, overrides every mode |
| mode | input | 2 | Operation code: 00 keep, 01 shift toward bit 0, 10 shift toward bit 3, 11 load |
| serInHigh | input | 1 | Serial bit entering at bit 3 on a shift toward bit 0 |
| serInLow | input | 1 | Serial bit entering at bit 0 on a shift toward bit 3 |
| loadWord | input | 4 | Parallel word taken in mode 11 |
| regOut | output | 4 | Current register contents |

## Verification
The bench targets these corner cases:
- Reset asserted together with a load of all ones. A design that lets the mode win over reset would show 1111.
- Serial inputs driven opposite to each other during shifts. A design that swaps the two serial inputs, or feeds the wrong end, gives the wrong end bit.
- Random serial and load values during keep and load cycles. This exposes a selector that lets an idle input leak into the register.
- A mode change halfway through a cycle. Any combinational path from the mode to the output would show as an early change.

The bench also replays the directed sequence from 1010 to catch a shift direction that is mirrored.

// File: rtl/bidirShiftPkg.sv
package bidirShiftPkg;

  localparam int REG_W = 4;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_KEEP  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } shiftMode_e;

  // One-hot strobes from control to datapath; all zero means keep.
  typedef struct packed {
    logic clear;
    logic take;
    logic moveDown;
    logic moveUp;
  } shiftStrobe_t;

endpackage

// File: rtl/bidirShiftCtrl.sv
module bidirShiftCtrl
  import bidirShiftPkg::*;
(
  input  logic                rst,
  input  logic [MODE_W-1:0]   mode,
  output shiftStrobe_t        stb
);

  always_comb begin
    stb = '0;
    if (rst) begin
      stb.clear = 1'b1;
    end else begin
      case (mode)
        MODE_RIGHT: stb.moveDown = 1'b1;
        MODE_LEFT:  stb.moveUp   = 1'b1;
        MODE_LOAD:  stb.take     = 1'b1;
        default:    stb          = '0;
      endcase
    end
  end

endmodule

// File: rtl/bidirShiftPath.sv
module bidirShiftPath
  import bidirShiftPkg::*;
#(
  parameter int W = REG_W
) (
  input  logic          clk,
  input  shiftStrobe_t  stb,
  input  logic          serInHigh,
  input  logic          serInLow,
  input  logic [W-1:0]  loadWord,
  output logic [W-1:0]  q
);

  logic [W-1:0] nextQ;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fromAbove;
    logic fromBelow;

    if (i == W-1) begin : g_top
      assign fromAbove = serInHigh;
    end else begin : g_midHi
      assign fromAbove = q[i+1];
    end

    if (i == 0) begin : g_bot
      assign fromBelow = serInLow;
    end else begin : g_midLo
      assign fromBelow = q[i-1];
    end

    always_comb begin
      if (stb.clear)         nextQ[i] = 1'b0;
      else if (stb.take)     nextQ[i] = loadWord[i];
      else if (stb.moveDown) nextQ[i] = fromAbove;
      else if (stb.moveUp)   nextQ[i] = fromBelow;
      else                   nextQ[i] = q[i];
    end
  end

  always_ff @(posedge clk) begin
    q <= nextQ;
  end

endmodule

// File: rtl/bidirShiftReg.sv
module bidirShiftReg
  import bidirShiftPkg::*;
#(
  parameter int W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              serInHigh,
  input  logic              serInLow,
  input  logic [W-1:0]      loadWord,
  output logic [W-1:0]      regOut
);

  shiftStrobe_t stb;

  bidirShiftCtrl ctrl_i (
    .rst  (rst),
    .mode (mode),
    .stb  (stb)
  );

  bidirShiftPath #(.W(W)) path_i (
    .clk       (clk),
    .stb       (stb),
    .serInHigh (serInHigh),
    .serInLow  (serInLow),
    .loadWord  (loadWord),
    .q         (regOut)
  );

endmodule

// File: rtl/bidirShiftReg_chk.sv
module bidirShiftReg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic         serInHigh,
  input logic         serInLow,
  input logic [W-1:0] loadWord,
  input logic [W-1:0] regOut
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> regOut == '0);

  assert_keep_stable_R2: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |=> $stable(regOut));

  assert_shift_down_R3: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |=> regOut == {$past(serInHigh), $past(regOut[W-1:1])});

  assert_shift_up_R4: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |=> regOut == {$past(regOut[W-2:0]), $past(serInLow)});

  assert_load_word_R5: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |=> regOut == $past(loadWord));

endmodule

bind bidirShiftReg bidirShiftReg_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .serInHigh (serInHigh),
  .serInLow  (serInLow),
  .loadWord  (loadWord),
  .regOut    (regOut)
);

// File: tb/bidirShiftReg_tb_top.sv
`timescale 1ns/1ps
module bidirShiftReg_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       serInHigh = 1'b0;
  logic       serInLow = 1'b0;
  logic [3:0] loadWord = 4'h0;
  logic [3:0] regOut;

  int total = 0;
  int bad = 0;
  logic [3:0] expVal = 4'h0;
  bit done = 0;

  always #5 clk = ~clk;

  bidirShiftReg dut_i (
    .clk(clk), .rst(rst), .mode(mode), .serInHigh(serInHigh),
    .serInLow(serInLow), .loadWord(loadWord), .regOut(regOut)
  );

  function automatic logic [3:0] model(logic [3:0] cur, logic r, logic [1:0] m,
                                       logic hi, logic lo, logic [3:0] ld);
    if (r) return 4'h0;
    case (m)
      2'b00: return cur;
      2'b01: return {hi, cur[3:1]};
      2'b10: return {cur[2:0], lo};
      default: return ld;
    endcase
  endfunction

  function automatic string tagFor(logic r, logic [1:0] m);
    if (r) return "R1";
    case (m)
      2'b00: return "R2 R7";
      2'b01: return "R3 R7";
      2'b10: return "R4 R7";
      default: return "R5 R7";
    endcase
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, wait one cycle, check at next negedge.
  task automatic step(logic r, logic [1:0] m, logic hi, logic lo, logic [3:0] ld);
    rst = r; mode = m; serInHigh = hi; serInLow = lo; loadWord = ld;
    expVal = model(expVal, r, m, hi, lo, ld);
    @(negedge clk);
    check(tagFor(r, m), regOut, expVal);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    expVal = 4'h0;
    check("R1 reset state", regOut, 4'h0);

    // R1: reset wins over a load of all ones
    step(1'b1, 2'b11, 1'b1, 1'b1, 4'hF);
    check("R1 priority over load", regOut, 4'h0);

    // R8 directed sequence
    step(1'b0, 2'b11, 1'b0, 1'b1, 4'b1010);
    step(1'b0, 2'b01, 1'b1, 1'b1, 4'h0);
    check("R8 first shift down", regOut, 4'b1101);
    step(1'b0, 2'b01, 1'b1, 1'b0, 4'h0);
    check("R8 second shift down", regOut, 4'b1110);
    step(1'b0, 2'b10, 1'b1, 1'b0, 4'h0);
    check("R8 shift up", regOut, 4'b1100);
    step(1'b0, 2'b11, 1'b1, 1'b1, 4'b0110);
    check("R8 load", regOut, 4'b0110);
    step(1'b0, 2'b10, 1'b1, 1'b0, 4'h9);
    check("R8 shift up after load", regOut, 4'b1100);

    // R7: opposite serial inputs during shifts, idle inputs during keep
    step(1'b0, 2'b01, 1'b0, 1'b1, 4'hF);
    check("R7 low serial ignored on shift down", regOut, 4'b0110);
    step(1'b0, 2'b10, 1'b0, 1'b1, 4'hF);
    check("R7 high serial ignored on shift up", regOut, 4'b1101);
    step(1'b0, 2'b00, 1'b1, 1'b1, 4'h0);
    check("R7 R2 keep ignores all data", regOut, 4'b1101);

    // R6: mode change mid-cycle has no effect before the edge
    rst = 1'b0; mode = 2'b11; loadWord = 4'h0;
    #2;
    check("R6 no change before edge", regOut, expVal);
    mode = 2'b00; loadWord = 4'h5;
    #1;
    check("R6 no change after mid-cycle mode edit", regOut, expVal);
    @(negedge clk);
    check("R6 keep taken at edge", regOut, expVal);

    // Random traffic
    for (int n = 0; n < 2000; n++) begin
      logic r;
      r = ($urandom % 64) == 0;
      step(r, 2'($urandom), 1'($urandom), 1'($urandom), 4'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule